// File: doc/BRIEF.md
# SDRAM Mode Register Command Sequencer

This block sits between a CPU-side register write port and the command pins of one SDRAM chip-select space. A single long-word write to a dedicated mode-setting address window starts a complete programming sequence: precharge-all, an optional burst of eight auto-refreshes, a mode register set and an extended mode register set. The triggering write carries every operand. The 12-bit offset within the window becomes the mode register value. The low 28 bits of the data become the extended mode register value. The top data nibble chooses whether the refreshes run.

Each command is followed by a programmable number of NOP cycles: the precharge wait, the refresh recovery and the post-mode-write gap. The data bus is never driven. While a sequence runs, the block drops its ready flag, and CPU writes made in that time are discarded.

Top module: `sdram_mrs_seq`

## Requirements
- R1: After reset, `cpu_ready` is 1, every `sd_cs_n` bit is 1, `sd_ras_n`/`sd_cas_n`/`sd_we_n` are 1, `sd_dq_oe` is 0 and `sd_addr`/`sd_ba` are 0.
- R2: A sequence is launched only by a write (`cpu_wr`=1 while `cpu_ready`=1) with `cpu_size`=2'b10 (long word; 2'b00 is byte, 2'b01 is word) whose address bits [31:12] equal `WIN_TAG`. A write of any other size or to any other address leaves every output unchanged.
- R3: If data bits [31:28] equal 0, the commands issued in order are precharge-all, exactly `N_REF` (8) auto-refreshes, mode set and extended mode set.
- R4: If data bits [31:28] equal 1, the order is precharge-all, mode set and extended mode set, with no refresh. Any other nibble value is ignored as in R2.
- R5: The command encodings on {CS#,RAS#,CAS#,WE#} of the selected space are: precharge 0010, auto-refresh 0001, mode/extended-mode set 0000, NOP 0111. Deselect (idle) is CS#=1 with RAS#/CAS#/WE#=1.
- R6: Precharge is followed by `T_PW` NOPs, each refresh by `T_RR` NOPs, and both mode set and extended mode set by `T_NOP` NOPs. The next command follows the last NOP directly, and precharge appears in the first cycle after the accepting clock edge.
- R7: During precharge-all, `sd_addr` bit `A10_BIT` is 1 and all other address bits are 0. During refresh and NOP cycles, `sd_addr` is 0 and `sd_ba` is 0.
- R8: The mode set drives the 12-bit window offset, zero-extended, on `sd_addr` with `sd_ba`=2'b00. The extended mode set drives data bits [27:0] on `sd_addr` with `sd_ba`=2'b10.
- R9: Only chip select `CS_SEL` (index 3) ever goes low. All other `sd_cs_n` bits stay 1.
- R10: `sd_dq_oe` stays 0 and `sd_dqm` stays all ones in every cycle.
- R11: `cpu_ready` is 0 from the first command cycle through the last NOP after the extended mode set, and is 1 in the cycle after that. Writes made while it is 0 have no effect on the sequence or on later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | ADDR_W | Write address |
| cpu_size | input | 2 | Access size: 00 byte, 01 word, 10 long word |
| cpu_data | input | DATA_W | Write data |
| cpu_ready | output | 1 | High when a write can start a sequence |
| sd_cs_n | output | N_CS | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | SDA_W | SDRAM address lines |
| sd_ba | output | 2 | Bank address |
| sd_dqm | output | DQM_W | Byte masks, held all ones |
| sd_dq_oe | output | 1 | Data-bus output enable, held low |

## Verification
The hardest condition to reach is a write that arrives while a sequence is in flight, because the port normally waits for the ready flag. The bench drives a fully valid launching write, with different offset and data, in the middle of the precharge wait. It then checks every remaining cycle of the trace against the operands of the first write, and checks that the block is idle afterwards. The sweep walks offsets and data patterns through both refresh and no-refresh sequences, so that every command slot and gap length is compared cycle by cycle.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

  typedef enum logic [2:0] {
    CMD_DES,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_EMRS
  } sd_cmd_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  // {cs_n, ras_n, cas_n, we_n} for the selected space
  function automatic logic [3:0] cmd_pins(sd_cmd_e c);
    case (c)
      CMD_NOP:  cmd_pins = 4'b0111;
      CMD_PRE:  cmd_pins = 4'b0010;
      CMD_REF:  cmd_pins = 4'b0001;
      CMD_MRS:  cmd_pins = 4'b0000;
      CMD_EMRS: cmd_pins = 4'b0000;
      default:  cmd_pins = 4'b1111;
    endcase
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    max3 = (m > c) ? m : c;
  endfunction

  // total cycles from precharge to the last NOP after the extended set
  function automatic int seq_cycles(bit with_ref, int n_ref, int t_pw, int t_rr, int t_nop);
    seq_cycles = 1 + t_pw + 2 * (1 + t_nop) + (with_ref ? n_ref * (1 + t_rr) : 0);
  endfunction

endpackage

// File: rtl/sdram_mrs_decode.sv
module sdram_mrs_decode #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 12,
  parameter logic [ADDR_W-OFS_W-1:0] WIN_TAG = 'hA4FD5
) (
  input  logic              wr,
  input  logic              ready,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] data,
  output logic              launch,
  output logic              with_ref
);
  import sdram_mrs_pkg::*;

  logic       hit;
  logic [3:0] nib;

  assign hit      = (addr[ADDR_W-1:OFS_W] == WIN_TAG);
  assign nib      = data[DATA_W-1 -: 4];
  assign with_ref = (nib == 4'd0);
  assign launch   = wr && ready && hit && (size == SZ_LONG) && (nib <= 4'd1);

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  AST_GAP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));  // R6

endmodule

// File: rtl/sdram_mrs_fsm.sv
module sdram_mrs_fsm #(
  parameter int N_REF = 8,
  parameter int T_PW  = 2,
  parameter int T_RR  = 7,
  parameter int T_NOP = 2,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch,
  input  logic                   with_ref,
  input  logic                   gap_last,
  output sdram_mrs_pkg::sd_cmd_e cmd,
  output logic                   busy,
  output logic                   tmr_load,
  output logic [CNT_W-1:0]       tmr_val
);
  import sdram_mrs_pkg::*;

  localparam int RC_W = $clog2(N_REF + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_GAP, ST_REF, ST_MRS, ST_EMRS} st_e;

  st_e             state, state_nx;
  st_e             prev_cmd;
  logic            do_ref;
  logic [RC_W-1:0] ref_left;
  logic            is_cmd_state;

  assign is_cmd_state = (state == ST_PRE) || (state == ST_REF) ||
                        (state == ST_MRS) || (state == ST_EMRS);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (launch) state_nx = ST_PRE;
      ST_PRE, ST_REF, ST_MRS, ST_EMRS: state_nx = ST_GAP;
      ST_GAP: if (gap_last) begin
        case (prev_cmd)
          ST_PRE:  state_nx = do_ref ? ST_REF : ST_MRS;
          ST_REF:  state_nx = (ref_left != '0) ? ST_REF : ST_MRS;
          ST_MRS:  state_nx = ST_EMRS;
          default: state_nx = ST_IDLE;
        endcase
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      prev_cmd <= ST_IDLE;
      do_ref   <= 1'b0;
      ref_left <= '0;
    end else begin
      state <= state_nx;
      if (is_cmd_state) prev_cmd <= state;
      if (state == ST_IDLE && launch) begin
        do_ref   <= with_ref;
        ref_left <= RC_W'(N_REF);
      end else if (state == ST_REF) begin
        ref_left <= ref_left - 1'b1;
      end
    end
  end

  always_comb begin
    tmr_load = is_cmd_state;
    case (state)
      ST_PRE:  tmr_val = CNT_W'(T_PW);
      ST_REF:  tmr_val = CNT_W'(T_RR);
      default: tmr_val = CNT_W'(T_NOP);
    endcase
  end

  always_comb begin
    case (state)
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  cmd = CMD_MRS;
      ST_EMRS: cmd = CMD_EMRS;
      ST_GAP:  cmd = CMD_NOP;
      default: cmd = CMD_DES;
    endcase
  end

  assign busy = (state != ST_IDLE);

  AST_CMD_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_state |=> (state == ST_GAP));  // R6
  AST_REF_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MRS) |-> (do_ref ? (ref_left == '0) : (ref_left == RC_W'(N_REF))));  // R3
  AST_EMRS_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMRS) |-> (prev_cmd == ST_MRS));  // R4
  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && launch) |=> (state == ST_PRE));  // R6

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFS_W   = 12,
  parameter int SDA_W   = 28,
  parameter int N_CS    = 8,
  parameter int CS_SEL  = 3,
  parameter int A10_BIT = 10,
  parameter int DQM_W   = 4,
  parameter logic [ADDR_W-OFS_W-1:0] WIN_TAG = 'hA4FD5,
  parameter int N_REF   = 8,
  parameter int T_PW    = 2,
  parameter int T_RR    = 7,
  parameter int T_NOP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              cpu_ready,
  output logic [N_CS-1:0]   sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [SDA_W-1:0]  sd_addr,
  output logic [1:0]        sd_ba,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              sd_dq_oe
);
  import sdram_mrs_pkg::*;

  localparam int CNT_W = $clog2(max3(T_PW, T_RR, T_NOP) + 1);
  localparam logic [N_CS-1:0] SEL_MASK = N_CS'(1) << CS_SEL;

  logic             launch, with_ref, busy;
  logic             tmr_load, gap_last;
  logic [CNT_W-1:0] tmr_val;
  sd_cmd_e          cmd;
  logic [3:0]       pins;
  logic [OFS_W-1:0] mrs_ofs_q;
  logic [SDA_W-1:0] emrs_val_q;

  sdram_mrs_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .WIN_TAG(WIN_TAG)
  ) u_decode (
    .wr(cpu_wr), .ready(cpu_ready), .addr(cpu_addr), .size(cpu_size),
    .data(cpu_data), .launch(launch), .with_ref(with_ref)
  );

  sdram_mrs_fsm #(
    .N_REF(N_REF), .T_PW(T_PW), .T_RR(T_RR), .T_NOP(T_NOP), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .with_ref(with_ref),
    .gap_last(gap_last), .cmd(cmd), .busy(busy),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sdram_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(gap_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs_ofs_q  <= '0;
      emrs_val_q <= '0;
    end else if (launch) begin
      mrs_ofs_q  <= cpu_addr[OFS_W-1:0];
      emrs_val_q <= cpu_data[SDA_W-1:0];
    end
  end

  assign pins      = cmd_pins(cmd);
  assign cpu_ready = !busy;
  assign sd_ras_n  = pins[2];
  assign sd_cas_n  = pins[1];
  assign sd_we_n   = pins[0];
  assign sd_dqm    = '1;
  assign sd_dq_oe  = 1'b0;

  generate
    for (genvar g = 0; g < N_CS; g++) begin : g_cs
      if (g == CS_SEL) begin : g_sel
        assign sd_cs_n[g] = pins[3];
      end else begin : g_off
        assign sd_cs_n[g] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    sd_addr = '0;
    sd_ba   = 2'b00;
    case (cmd)
      CMD_PRE:  sd_addr = SDA_W'(1) << A10_BIT;
      CMD_MRS:  sd_addr = SDA_W'(mrs_ofs_q);
      CMD_EMRS: begin
        sd_addr = emrs_val_q;
        sd_ba   = 2'b10;
      end
      default: ;
    endcase
  end

  AST_PRE_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n[CS_SEL] && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[A10_BIT]);  // R7
  AST_ONLY_SEL_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sd_cs_n[CS_SEL] && ((sd_cs_n | SEL_MASK) == '1)));  // R9
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_wr) |=> ($stable(mrs_ofs_q) && $stable(emrs_val_q)));  // R11
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (sd_cs_n == '1));  // R1

endmodule

// File: tb/test_sdram_mrs_seq.sv
module test_sdram_mrs_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, DATA_W = 32, OFS_W = 12, SDA_W = 28;
  localparam int N_CS = 8, CS_SEL = 3, A10_BIT = 10, DQM_W = 4;
  localparam int N_REF = 8, T_PW = 2, T_RR = 3, T_NOP = 1;
  localparam logic [19:0] TAG = 20'hA4FD5;
  localparam int WD_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_wr = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [1:0]        cpu_size = 2'b00;
  logic [DATA_W-1:0] cpu_data = '0;
  logic              cpu_ready;
  logic [N_CS-1:0]   sd_cs_n;
  logic              sd_ras_n, sd_cas_n, sd_we_n;
  logic [SDA_W-1:0]  sd_addr;
  logic [1:0]        sd_ba;
  logic [DQM_W-1:0]  sd_dqm;
  logic              sd_dq_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  sdram_mrs_seq #(
    .N_REF(N_REF), .T_PW(T_PW), .T_RR(T_RR), .T_NOP(T_NOP)
  ) i_sdram_mrs_seq (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_data(cpu_data), .cpu_ready(cpu_ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .sd_dqm(sd_dqm), .sd_dq_oe(sd_dq_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // bench codes: 0 deselect, 1 nop, 2 precharge, 3 refresh, 4 mode set, 5 ext mode set, 7 bad
  function automatic int seen_code();
    if (sd_cs_n[CS_SEL]) return (sd_ras_n && sd_cas_n && sd_we_n) ? 0 : 7;
    case ({sd_ras_n, sd_cas_n, sd_we_n})
      3'b111: return 1;
      3'b010: return 2;
      3'b001: return 3;
      3'b000: return (sd_ba == 2'b10) ? 5 : 4;
      default: return 7;
    endcase
  endfunction

  function automatic int want_code(int k, bit refr);
    int p;
    p = k;
    if (p == 0) return 2;
    p = p - 1;
    if (p < T_PW) return 1;
    p = p - T_PW;
    if (refr) begin
      for (int i = 0; i < N_REF; i++) begin
        if (p == 0) return 3;
        p = p - 1;
        if (p < T_RR) return 1;
        p = p - T_RR;
      end
    end
    if (p == 0) return 4;
    p = p - 1;
    if (p < T_NOP) return 1;
    p = p - T_NOP;
    if (p == 0) return 5;
    return 1;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(string tag);
    check(cpu_ready == 1'b1, {tag, " ready"}, cpu_ready, 1);
    check(sd_cs_n == '1 && sd_ras_n && sd_cas_n && sd_we_n, {tag, " deselect"},
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 11'h7FF);
    check(sd_dq_oe == 1'b0 && sd_dqm == '1, {tag, " R10 bus"}, {sd_dq_oe, sd_dqm}, 5'h0F);
  endtask

  task automatic write_once(logic [31:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_size = s; cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic ignored_write(logic [31:0] a, logic [1:0] s, logic [31:0] d, string tag);
    write_once(a, s, d);
    for (int k = 0; k < 3; k++) begin
      check_idle(tag);
      @(negedge clk);
    end
  endtask

  task automatic run_seq(logic [OFS_W-1:0] ofs, logic [27:0] val, bit refr, bit poke);
    int len, w;
    logic [SDA_W-1:0] ea;
    len = 1 + T_PW + 2 * (1 + T_NOP) + (refr ? N_REF * (1 + T_RR) : 0);
    write_once({TAG, ofs}, 2'b10, {refr ? 4'h0 : 4'h1, val});
    for (int k = 0; k < len; k++) begin
      w = want_code(k, refr);
      check(seen_code() == w, refr ? "R3 order" : "R4 order", seen_code(), w);
      check((sd_cs_n | (N_CS'(1) << CS_SEL)) == '1, "R9 other cs", sd_cs_n, 8'hF7);
      check(sd_dq_oe == 1'b0 && sd_dqm == '1, "R10 bus", {sd_dq_oe, sd_dqm}, 5'h0F);
      check(cpu_ready == 1'b0, "R11 busy", cpu_ready, 0);
      case (w)
        2: ea = SDA_W'(1) << A10_BIT;
        4: ea = SDA_W'(ofs);
        5: ea = val;
        default: ea = '0;
      endcase
      check(sd_addr == ea, "R7 R8 addr", sd_addr, ea);
      check(sd_ba == ((w == 5) ? 2'b10 : 2'b00), "R8 bank", sd_ba, (w == 5) ? 2 : 0);
      if (poke && k == 2) begin
        cpu_wr = 1'b1; cpu_addr = {TAG, ~ofs}; cpu_size = 2'b10;
        cpu_data = {4'h0, ~val};
      end else begin
        cpu_wr = 1'b0;
      end
      @(negedge clk);
    end
    check_idle("R6 R11 end");
    @(negedge clk);
    check_idle("R11 after");
  endtask

  initial begin
    logic [OFS_W-1:0] ofs;
    logic [27:0] val;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    check(sd_addr == '0 && sd_ba == '0, "R1 addr", sd_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 released");

    ignored_write({TAG, 12'h123}, 2'b00, 32'h0000_0055, "R2 byte");
    ignored_write({TAG, 12'h123}, 2'b01, 32'h0000_0055, "R2 word");
    ignored_write({20'hA4FD4, 12'h123}, 2'b10, 32'h0000_0055, "R2 addr");
    ignored_write({20'h24FD5, 12'h123}, 2'b10, 32'h1000_0055, "R2 addr hi");
    ignored_write({TAG, 12'h123}, 2'b11, 32'h0000_0055, "R2 size 3");
    ignored_write({TAG, 12'h123}, 2'b10, 32'h2000_0055, "R4 nibble 2");
    ignored_write({TAG, 12'h123}, 2'b10, 32'hF000_0055, "R4 nibble F");

    for (int i = 0; i < 16; i++) begin
      case (i)
        0: ofs = 12'h000;
        1: ofs = 12'hFFF;
        2: ofs = 12'h555;
        3: ofs = 12'hAAA;
        default: ofs = 12'(1) << (i - 4);
      endcase
      val = {ofs[3:0], ofs, ofs} ^ 28'(i * 32'h0012_3457);
      run_seq(ofs, val, 1'b1, 1'b0);   // R3 R5 R6
      run_seq(~ofs, ~val, 1'b0, 1'b0); // R4 R5 R6
    end
    run_seq(12'h432, 28'h89A_BCDE, 1'b1, 1'b1); // R11 write during busy
    run_seq(12'h0F0, 28'h000_0400, 1'b0, 1'b1); // R11

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule